// File: doc/BRIEF.md
# Instruction-Timed Watchdog With Activation Control

This block is a watchdog timer clocked by retired instructions rather than by raw clock cycles. A six-bit down-counter steps once every 28 instruction strobes. When the counter has reached zero and one more step comes due, the block raises a one-cycle reset pulse. Software holds the timer off by rewriting its single control register before that point. Each write reloads the count and restarts the instruction prescaler.

A level on the activation-select input picks the start-up behaviour. Low means the timer is already running when reset releases. High means it stays idle until software sets the enable bit. Once running, the timer cannot be stopped by any write; only a system reset stops it. While the timer runs, a request to enter stop mode is turned into a wait request, so the countdown is never frozen by a deep sleep. The block merges its own timeout pulse with the power-on and external reset inputs into one system reset output. That same merged reset re-initialises the block.

The control register is eight bits wide:
- Bit 0 is the enable bit.
- Bit 1 is an active-low software-reset bit.
- Bits 7:2 hold the counter value, with bit 2 as its least significant bit.

Top module: `insn_watchdog`

## Requirements
- R1: With sw_mode_i high during reset, the register reads 0xFE after reset: enable (bit 0) clear, software-reset bit (bit 1) set, counter bits 7:2 all ones.
- R2: With sw_mode_i low during reset, the enable bit is set by the reset itself, and the register reads 0xFF.
- R3: Writing 0 to bit 0 never clears an enable bit that is set; only a system reset clears it.
- R4: A write loads bits 7:2 and bit 1 from wr_data_i, ORs bit 0 into the enable bit, and restarts the instruction prescaler; the new value is readable in the cycle after the write.
- R5: While enabled, the counter drops by one on every 28th strobe of retire_i counted since the last write or reset; while disabled, neither the counter nor the prescaler moves.
- R6: When the counter is zero and its next step comes due, wdt_rst_o and sys_rst_o are high for exactly the following cycle, and the register then returns to its reset value. A counter written as N therefore expires after (N+1)*28 strobes, and never fewer than 28 after activation.
- R7: A write with bit 1 equal to 0 produces the reset pulse in the next cycle if the enable bit is set or is being set by that write; otherwise it produces no pulse.
- R8: While enabled, stop_req_i is steered to wait_o and stop_o stays low; while disabled, stop_req_i passes to stop_o. wait_req_i always passes to wait_o.
- R9: sys_rst_o is high whenever por_i or ext_rst_i is high or a watchdog pulse is present, and either input re-initialises the register.
- R10: A write in the same cycle as a due step takes precedence: no reset pulse occurs, and the written value is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| ext_rst_i | input | 1 | External reset request, synchronous, active high |
| sw_mode_i | input | 1 | Activation select: 0 = running from reset, 1 = software enable |
| retire_i | input | 1 | One pulse per retired instruction |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write value |
| rd_data_o | output | 8 | Current control register value |
| stop_req_i | input | 1 | Request to enter stop mode |
| wait_req_i | input | 1 | Request to enter wait mode |
| stop_o | output | 1 | Granted stop mode |
| wait_o | output | 1 | Granted wait mode |
| wdt_rst_o | output | 1 | One-cycle watchdog timeout pulse |
| sys_rst_o | output | 1 | Combined system reset |

## Verification
The two functions that can land on the same cycle are a software reload and the prescaler step that would underflow a zero counter. The bench walks an enabled counter down to zero and runs 27 further strobes. It then drives the 28th strobe in the same cycle as a register write. The outcome is judged correct only if no reset pulse appears and the register shows the written value in the following cycle.

// File: rtl/insn_wdt_pkg.sv
package insn_wdt_pkg;

    localparam int CNT_W = 6;
    localparam int REG_W = CNT_W + 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sr_n;
        logic             en;
    } wdt_ctl_t;

    function automatic wdt_ctl_t ctl_reset_value(input logic hw_act);
        wdt_ctl_t v;
        v.cnt  = '1;
        v.sr_n = 1'b1;
        v.en   = hw_act;
        return v;
    endfunction

endpackage

// File: rtl/insn_wdt_prescaler.sv
module insn_wdt_prescaler #(
    parameter int PRE_DIV = 28
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic strobe,
    output logic tick
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick = run && strobe && (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
        end else if (run && strobe) begin
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/insn_wdt_ctl.sv
module insn_wdt_ctl
    import insn_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_act,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             tick,
    output wdt_ctl_t         ctl,
    output logic             expire
);
    wdt_ctl_t ctl_q;
    wdt_ctl_t wr_val;

    assign wr_val = wdt_ctl_t'(wdata);
    assign ctl    = ctl_q;

    always_comb begin
        if (wr) begin
            expire = !wr_val.sr_n && (ctl_q.en || wr_val.en);
        end else begin
            expire = tick && (ctl_q.cnt == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= ctl_reset_value(hw_act);
        end else if (wr) begin
            ctl_q.cnt  <= wr_val.cnt;
            ctl_q.sr_n <= wr_val.sr_n;
            ctl_q.en   <= ctl_q.en | wr_val.en;
        end else if (tick && (ctl_q.cnt != '0)) begin
            ctl_q.cnt <= ctl_q.cnt - 1'b1;
        end
    end
endmodule

// File: rtl/insn_wdt_lowpower.sv
module insn_wdt_lowpower (
    input  logic active,
    input  logic stop_req,
    input  logic wait_req,
    output logic stop_gnt,
    output logic wait_gnt
);
    always_comb begin
        stop_gnt = stop_req && !active;
        wait_gnt = wait_req || (stop_req && active);
    end
endmodule

// File: rtl/insn_watchdog.sv
module insn_watchdog
    import insn_wdt_pkg::*;
#(
    parameter int PRE_DIV = 28
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             ext_rst_i,
    input  logic             sw_mode_i,
    input  logic             retire_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             stop_req_i,
    input  logic             wait_req_i,
    output logic             stop_o,
    output logic             wait_o,
    output logic             wdt_rst_o,
    output logic             sys_rst_o
);
    logic     fire_q;
    logic     int_rst;
    logic     tick;
    logic     expire;
    wdt_ctl_t ctl;

    assign int_rst = por_i || ext_rst_i || fire_q;

    insn_wdt_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst     (int_rst),
        .run     (ctl.en),
        .restart (wr_en_i),
        .strobe  (retire_i),
        .tick    (tick)
    );

    insn_wdt_ctl u_ctl (
        .clk    (clk),
        .rst    (int_rst),
        .hw_act (!sw_mode_i),
        .wr     (wr_en_i),
        .wdata  (wr_data_i),
        .tick   (tick),
        .ctl    (ctl),
        .expire (expire)
    );

    insn_wdt_lowpower u_lp (
        .active   (ctl.en),
        .stop_req (stop_req_i),
        .wait_req (wait_req_i),
        .stop_gnt (stop_o),
        .wait_gnt (wait_o)
    );

    always_ff @(posedge clk) begin
        if (por_i || ext_rst_i) begin
            fire_q <= 1'b0;
        end else begin
            fire_q <= expire && !fire_q;
        end
    end

    assign rd_data_o = ctl;
    assign wdt_rst_o = fire_q;
    assign sys_rst_o = int_rst;
endmodule

// File: rtl/insn_watchdog_chk.sv
module insn_watchdog_chk (
    input logic       clk,
    input logic       por_i,
    input logic       sw_mode_i,
    input logic       wr_en_i,
    input logic [7:0] rd_data_o,
    input logic       stop_o,
    input logic       wdt_rst_o,
    input logic       sys_rst_o
);
    // R6: the timeout pulse lasts a single cycle
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (por_i)
        wdt_rst_o |=> !wdt_rst_o);

    // R3: enable stays set until a system reset
    p_enable_sticky_r3: assert property (@(posedge clk) disable iff (por_i)
        (rd_data_o[0] && !sys_rst_o) |=> rd_data_o[0]);

    // R1: reset loads counter and software-reset bit with ones
    p_reset_value_r1: assert property (@(posedge clk) disable iff (por_i)
        sys_rst_o |=> (rd_data_o[7:1] == 7'h7F));

    // R2: low activation select starts the timer running
    p_hw_start_r2: assert property (@(posedge clk) disable iff (por_i)
        (sys_rst_o && !sw_mode_i) |=> rd_data_o[0]);

    // R5: counter moves by at most one step without a write or reset
    p_count_step_r5: assert property (@(posedge clk) disable iff (por_i)
        (!sys_rst_o && !wr_en_i) |=>
        ((rd_data_o[7:2] == $past(rd_data_o[7:2])) ||
         (rd_data_o[7:2] == 6'($past(rd_data_o[7:2]) - 6'd1))));

    // R5: a disabled timer never expires on its own
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (por_i)
        (!rd_data_o[0] && !wr_en_i) |=> !wdt_rst_o);

    // R8: no stop grant while the timer runs
    p_no_stop_r8: assert property (@(posedge clk) disable iff (por_i)
        rd_data_o[0] |-> !stop_o);
endmodule

bind insn_watchdog insn_watchdog_chk u_chk (
    .clk       (clk),
    .por_i     (por_i),
    .sw_mode_i (sw_mode_i),
    .wr_en_i   (wr_en_i),
    .rd_data_o (rd_data_o),
    .stop_o    (stop_o),
    .wdt_rst_o (wdt_rst_o),
    .sys_rst_o (sys_rst_o)
);

// File: tb/insn_watchdog_tb_top.sv
module insn_watchdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 28;
    localparam int WD_LIMIT = 100000;

    // {enable, stop_req, wait_req, exp_stop, exp_wait}
    localparam logic [4:0] LP_TAB [8] = '{
        5'b000_00, 5'b001_01, 5'b010_10, 5'b011_11,
        5'b100_00, 5'b101_01, 5'b110_01, 5'b111_01
    };

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       ext_rst_i = 1'b0;
    logic       sw_mode_i = 1'b1;
    logic       retire_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       stop_req_i = 1'b0;
    logic       wait_req_i = 1'b0;
    logic       stop_o, wait_o, wdt_rst_o, sys_rst_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_watchdog dut_i (
        .clk        (clk),
        .por_i      (por_i),
        .ext_rst_i  (ext_rst_i),
        .sw_mode_i  (sw_mode_i),
        .retire_i   (retire_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rd_data_o  (rd_data_o),
        .stop_req_i (stop_req_i),
        .wait_req_i (wait_req_i),
        .stop_o     (stop_o),
        .wait_o     (wait_o),
        .wdt_rst_o  (wdt_rst_o),
        .sys_rst_o  (sys_rst_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WD_LIMIT) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected<%0d cycles", cycles, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_por(input logic sw);
        sw_mode_i = sw;
        por_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        por_i = 1'b0;
    endtask

    task automatic do_wr(input logic [7:0] v);
        wr_en_i = 1'b1;
        wr_data_i = v;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            retire_i = 1'b1;
            @(negedge clk);
        end
        retire_i = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // R8: low-power steering table
        for (int k = 0; k < 8; k++) begin
            do_por(!LP_TAB[k][4]);
            stop_req_i = LP_TAB[k][3];
            wait_req_i = LP_TAB[k][2];
            #(CLK_PERIOD/4);
            chk("R8 stop_o", {7'd0, stop_o}, {7'd0, LP_TAB[k][1]});
            chk("R8 wait_o", {7'd0, wait_o}, {7'd0, LP_TAB[k][0]});
            @(negedge clk);
        end
        stop_req_i = 1'b0;
        wait_req_i = 1'b0;

        // R1: software-activation reset state
        do_por(1'b1);
        chk("R1 reset value", rd_data_o, 8'hFE);
        chk("R1 no pulse", {7'd0, wdt_rst_o}, 8'h00);

        // R5: disabled timer frozen
        strobe(60);
        chk("R5 frozen while disabled", rd_data_o, 8'hFE);

        // R4 / R7: writes while disabled
        do_wr(8'h16);
        chk("R4 readback", rd_data_o, 8'h16);
        do_wr(8'h14);
        chk("R7 no pulse while disabled", {7'd0, wdt_rst_o}, 8'h00);
        chk("R7 value loaded", rd_data_o, 8'h14);

        // R4 enable, R3 sticky
        do_wr(8'h0B);
        chk("R4 enable write", rd_data_o, 8'h0B);
        do_wr(8'h0A);
        chk("R3 enable kept", rd_data_o, 8'h0B);

        // R5 / R6 countdown from 2
        strobe(DIV - 1);
        chk("R5 no step before 28", rd_data_o, 8'h0B);
        strobe(1);
        chk("R5 first step", rd_data_o, 8'h07);
        strobe(DIV);
        chk("R5 second step", rd_data_o, 8'h03);
        strobe(DIV - 1);
        chk("R6 no early pulse", {7'd0, wdt_rst_o}, 8'h00);
        strobe(1);
        chk("R6 pulse", {7'd0, wdt_rst_o}, 8'h01);
        chk("R6 sys reset", {7'd0, sys_rst_o}, 8'h01);
        @(negedge clk);
        chk("R6 pulse ends", {7'd0, wdt_rst_o}, 8'h00);
        chk("R6 R3 back to reset value", rd_data_o, 8'hFE);

        // R6 minimum run after activation with zero count
        do_wr(8'h03);
        strobe(DIV - 1);
        chk("R6 min run no pulse", {7'd0, wdt_rst_o}, 8'h00);
        strobe(1);
        chk("R6 min run pulse", {7'd0, wdt_rst_o}, 8'h01);
        @(negedge clk);

        // R4 prescaler restart on write
        do_wr(8'h07);
        strobe(20);
        do_wr(8'h07);
        strobe(DIV - 1);
        chk("R4 prescaler restarted", rd_data_o, 8'h07);
        strobe(1);
        chk("R4 step after restart", rd_data_o, 8'h03);

        // R10: write collides with due step
        strobe(DIV - 1);
        retire_i = 1'b1;
        wr_en_i = 1'b1;
        wr_data_i = 8'h0F;
        @(negedge clk);
        retire_i = 1'b0;
        wr_en_i = 1'b0;
        chk("R10 no pulse", {7'd0, wdt_rst_o}, 8'h00);
        chk("R10 write loaded", rd_data_o, 8'h0F);

        // R7 software reset while enabled
        do_wr(8'h0D);
        chk("R7 sw reset pulse", {7'd0, wdt_rst_o}, 8'h01);
        @(negedge clk);
        chk("R7 after sw reset", rd_data_o, 8'hFE);
        do_wr(8'h01);
        chk("R7 enabling write with sr low", {7'd0, wdt_rst_o}, 8'h01);
        @(negedge clk);

        // R2 hardware activation, full countdown
        do_por(1'b0);
        chk("R2 reset value", rd_data_o, 8'hFF);
        strobe(64 * DIV - 1);
        chk("R2 counted to zero", rd_data_o, 8'h03);
        chk("R2 no pulse yet", {7'd0, wdt_rst_o}, 8'h00);
        strobe(1);
        chk("R2 timeout pulse", {7'd0, wdt_rst_o}, 8'h01);
        @(negedge clk);
        chk("R2 running again", rd_data_o, 8'hFF);

        // R9 external reset
        do_wr(8'h1F);
        chk("R9 before ext", rd_data_o, 8'h1F);
        ext_rst_i = 1'b1;
        #(CLK_PERIOD/4);
        chk("R9 sys reset from ext", {7'd0, sys_rst_o}, 8'h01);
        @(negedge clk);
        ext_rst_i = 1'b0;
        chk("R9 ext reinit", rd_data_o, 8'hFF);
        #(CLK_PERIOD/4);
        chk("R9 sys reset released", {7'd0, sys_rst_o}, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule